// File: doc/BRIEF.md
# Periodic Video Load-Detect Controller

This block sequences load detection for a video output stage with two ports: a composite port and a luma port. The chroma driver follows the luma driver. The block counts video fields by their vertical-sync strobes. Once every 64 fields, right after the strobe, it opens a check window on both ports. The analog comparators, test-current sources and output drivers sit outside the block. Their results arrive here as single digital bits.

Each port holds one bit of state: awake or asleep.
- **Awake port.** The output level is compared with a reference. A level above the reference means the load has been removed, so the driver is switched off.
- **Asleep port.** The driver stays off. A small test current is switched on for the window instead, and the impedance comparator reports whether a load has appeared. If it has, the driver is switched on.

The per-port presence flags are ORed into a single TV-present output. A one-cycle done pulse marks the end of each completed window. Everything is gated by a chip-enable input.

Top module: `vld_ctrl`

## Requirements
- R1: A 6-bit field counter advances on every `vsync_stb` cycle while `chip_en` is high. The strobe that takes the counter from 63 to 0 opens a check window. That is the 64th strobe counted after reset, after `chip_en` returns high, or after the previous window opened.
- R2: A window stays open for `SETTLE_CYCLES` cycles, starting in the cycle after the opening strobe. `check_done` is high for exactly one cycle, the cycle after the last window cycle. The presence flags take their new values in that same cycle and change at no other time.
- R3: The comparator inputs are sampled once, on the last cycle of the window. Their values in earlier window cycles have no effect.
- R4: For an awake port, `cmp_level`=1 at the sample point turns its driver off and clears its flag. `cmp_level`=0 leaves the port awake.
- R5: `test_en` for a port is high only during an open window, only while that port is asleep, and only while `chip_en` is high. Bit 0 is the composite port and bit 1 is the luma port; the same bit order applies to every per-port vector.
- R6: For an asleep port, `cmp_load`=1 at the sample point turns its driver on and sets its flag. `cmp_load`=0 leaves the port asleep.
- R7: The two ports are decided independently in the same window. `drv_en_c` always equals `drv_en_y`.
- R8: Driving `chip_en` low clears the field counter and closes any open window without updating a port and without a `check_done` pulse. This holds even when it happens on the sampling cycle.
- R9: After reset, all drivers, test currents, flags, `tv_det` and `check_done` are 0, so the first window tests both ports asleep.
- R10: `tv_det` is the OR of the two presence flags.
- R11: While `chip_en` is low, all driver enables and test-current enables are 0 and the presence flags hold their values. When `chip_en` returns, the drivers resume according to the held port state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable; low forces outputs off and clears sequencing |
| vsync_stb | input | 1 | One-cycle strobe per vertical sync |
| cmp_level | input | 2 | Awake-mode comparator per port, 1 = output level above reference (load gone) |
| cmp_load | input | 2 | Asleep-mode comparator per port, 1 = test current sees a load |
| drv_en_cv | output | 1 | Composite driver enable |
| drv_en_y | output | 1 | Luma driver enable |
| drv_en_c | output | 1 | Chroma driver enable (equals luma) |
| test_en | output | 2 | Test-current enable per port |
| present | output | 2 | Presence flag per port |
| tv_det | output | 1 | Any port has a load |
| check_done | output | 1 | One-cycle pulse at the end of a completed window |

## Verification
Two events can land in the same cycle: the result sample on the last window cycle and a falling chip enable. The bench drops `chip_en` in exactly that cycle with the comparators set to flip both ports. It then expects no done pulse and unchanged flags.

A second coincidence is exercised as well: one port waking while the other stays put, within a single sample. The bench judges each port's enable separately and checks that chroma tracks luma.

// File: rtl/vld_pkg.sv
`timescale 1ns/1ps
package vld_pkg;

    localparam int NUM_PORTS = 2;
    localparam int PORT_CV   = 0;
    localparam int PORT_Y    = 1;

    typedef enum logic {
        PORT_SLEEP = 1'b0,
        PORT_AWAKE = 1'b1
    } port_mode_e;

    typedef struct packed {
        logic active;
        logic last;
    } win_stat_t;

    // Decide the next port mode from the comparator that applies to the current mode.
    function automatic port_mode_e next_mode(port_mode_e cur, logic lvl_high, logic load_seen);
        port_mode_e nxt;
        if (cur == PORT_AWAKE)
            nxt = lvl_high ? PORT_SLEEP : PORT_AWAKE;
        else
            nxt = load_seen ? PORT_AWAKE : PORT_SLEEP;
        return nxt;
    endfunction

endpackage

// File: rtl/vld_field_sched.sv
`timescale 1ns/1ps
module vld_field_sched import vld_pkg::*; #(
    parameter int FIELD_BITS    = 6,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      chip_en,
    input  logic      vsync_stb,
    output win_stat_t win,
    output logic      check_done
);
    localparam int WIN_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(SETTLE_CYCLES - 1);

    logic [FIELD_BITS-1:0] fld_cnt;
    logic [WIN_W-1:0]      win_cnt;
    logic                  win_open;
    logic                  wrap;

    assign wrap       = vsync_stb && (fld_cnt == '1);
    assign win.active = win_open;
    assign win.last   = win_open && (win_cnt == WIN_LAST);

    always_ff @(posedge clk) begin
        if (rst || !chip_en) begin
            fld_cnt    <= '0;
            win_cnt    <= '0;
            win_open   <= 1'b0;
            check_done <= 1'b0;
        end else begin
            check_done <= 1'b0;
            if (vsync_stb)
                fld_cnt <= fld_cnt + 1'b1;
            if (win_open) begin
                if (win.last) begin
                    win_open   <= 1'b0;
                    win_cnt    <= '0;
                    check_done <= 1'b1;
                end else begin
                    win_cnt <= win_cnt + 1'b1;
                end
            end else if (wrap) begin
                win_open <= 1'b1;
                win_cnt  <= '0;
            end
        end
    end

endmodule

// File: rtl/vld_port.sv
`timescale 1ns/1ps
module vld_port import vld_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic chip_en,
    input  logic win_active,
    input  logic sample,
    input  logic cmp_level,
    input  logic cmp_load,
    output logic drv_en,
    output logic test_en,
    output logic present
);
    port_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst)
            mode <= PORT_SLEEP;
        else if (sample && chip_en)
            mode <= next_mode(mode, cmp_level, cmp_load);
    end

    assign present = (mode == PORT_AWAKE);
    assign drv_en  = chip_en && (mode == PORT_AWAKE);
    assign test_en = chip_en && win_active && (mode == PORT_SLEEP);

endmodule

// File: rtl/vld_ctrl.sv
`timescale 1ns/1ps
module vld_ctrl import vld_pkg::*; #(
    parameter int FIELD_BITS    = 6,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chip_en,
    input  logic                 vsync_stb,
    input  logic [NUM_PORTS-1:0] cmp_level,
    input  logic [NUM_PORTS-1:0] cmp_load,
    output logic                 drv_en_cv,
    output logic                 drv_en_y,
    output logic                 drv_en_c,
    output logic [NUM_PORTS-1:0] test_en,
    output logic [NUM_PORTS-1:0] present,
    output logic                 tv_det,
    output logic                 check_done
);
    win_stat_t            win;
    logic                 win_active;
    logic [NUM_PORTS-1:0] drv_vec;

    vld_field_sched #(
        .FIELD_BITS   (FIELD_BITS),
        .SETTLE_CYCLES(SETTLE_CYCLES)
    ) u_sched (
        .clk       (clk),
        .rst       (rst),
        .chip_en   (chip_en),
        .vsync_stb (vsync_stb),
        .win       (win),
        .check_done(check_done)
    );

    assign win_active = win.active;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        vld_port u_port (
            .clk       (clk),
            .rst       (rst),
            .chip_en   (chip_en),
            .win_active(win.active),
            .sample    (win.last),
            .cmp_level (cmp_level[p]),
            .cmp_load  (cmp_load[p]),
            .drv_en    (drv_vec[p]),
            .test_en   (test_en[p]),
            .present   (present[p])
        );
    end

    assign drv_en_cv = drv_vec[PORT_CV];
    assign drv_en_y  = drv_vec[PORT_Y];
    assign drv_en_c  = drv_vec[PORT_Y];
    assign tv_det    = |present;

endmodule

// File: rtl/vld_ctrl_chk.sv
`timescale 1ns/1ps
module vld_ctrl_chk #(
    parameter int SETTLE_CYCLES = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       chip_en,
    input logic       win_active,
    input logic       drv_en_cv,
    input logic       drv_en_y,
    input logic       drv_en_c,
    input logic [1:0] test_en,
    input logic [1:0] present,
    input logic       tv_det,
    input logic       check_done
);
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else if (win_active)
            run_len <= run_len + 1'b1;
        else
            run_len <= '0;
    end

    AST_WIN_LENGTH: assert property (@(posedge clk) disable iff (rst)
        check_done |-> (int'(run_len) == SETTLE_CYCLES)); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        check_done |=> !check_done); // R2
    AST_FLAG_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(present) |-> check_done); // R2
    AST_FLAG_HOLD_CE_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(present) |-> $past(chip_en)); // R11
    AST_CE_LOW_QUIET: assert property (@(posedge clk) disable iff (rst)
        !chip_en |-> (!drv_en_cv && !drv_en_y && !drv_en_c && test_en == 2'b00)); // R11
    AST_TEST_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (test_en != 2'b00) |-> win_active); // R5
    AST_TEST_CV_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        test_en[0] |-> !drv_en_cv && !present[0]); // R5
    AST_TEST_Y_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        test_en[1] |-> !drv_en_y && !present[1]); // R5
    AST_CHROMA_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        drv_en_c == drv_en_y); // R7
    AST_TVDET_ANY: assert property (@(posedge clk) disable iff (rst)
        tv_det == (present != 2'b00)); // R10

endmodule

bind vld_ctrl vld_ctrl_chk #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .chip_en   (chip_en),
    .win_active(win_active),
    .drv_en_cv (drv_en_cv),
    .drv_en_y  (drv_en_y),
    .drv_en_c  (drv_en_c),
    .test_en   (test_en),
    .present   (present),
    .tv_det    (tv_det),
    .check_done(check_done)
);

// File: tb/vld_ctrl_tb_top.sv
`timescale 1ns/1ps
module vld_ctrl_tb_top;
    localparam int SETTLE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_en = 1'b0;
    logic       vsync_stb = 1'b0;
    logic [1:0] cmp_level = 2'b00;
    logic [1:0] cmp_load = 2'b00;
    logic       drv_en_cv, drv_en_y, drv_en_c, tv_det, check_done;
    logic [1:0] test_en, present;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vld_ctrl #(.FIELD_BITS(6), .SETTLE_CYCLES(SETTLE)) dut_i (
        .clk(clk), .rst(rst), .chip_en(chip_en), .vsync_stb(vsync_stb),
        .cmp_level(cmp_level), .cmp_load(cmp_load),
        .drv_en_cv(drv_en_cv), .drv_en_y(drv_en_y), .drv_en_c(drv_en_c),
        .test_en(test_en), .present(present), .tv_det(tv_det), .check_done(check_done)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic fields(int n);
        for (int i = 0; i < n; i++) begin
            vsync_stb = 1'b1;
            tick();
            vsync_stb = 1'b0;
            tick(2);
        end
    endtask

    // Leaves the bench in the first window cycle.
    task automatic open_window();
        fields(63);
        vsync_stb = 1'b1;
        tick();
        vsync_stb = 1'b0;
    endtask

    // From the first window cycle to the cycle after the sample edge.
    task automatic close_window(logic [1:0] lvl, logic [1:0] ld);
        tick(SETTLE - 1);
        chk("R2 done low on last window cycle", int'(check_done), 0);
        cmp_level = lvl;
        cmp_load  = ld;
        tick();
        chk("R2 done pulse", int'(check_done), 1);
    endtask

    task automatic t_reset();
        tick(3);
        chk("R9 drivers off", int'({drv_en_cv, drv_en_y, drv_en_c}), 0);
        chk("R9 flags low", int'(present), 0);
        chk("R9 tv_det low", int'(tv_det), 0);
        rst = 1'b0;
        chip_en = 1'b1;
        tick();
        chk("R9 test off after reset", int'(test_en), 0);
        chk("R9 done low", int'(check_done), 0);
    endtask

    task automatic t_first_window();
        fields(63);
        chk("R1 no window before 64th strobe", int'(test_en), 0);
        vsync_stb = 1'b1;
        tick();
        vsync_stb = 1'b0;
        chk("R5 both test currents in sleep window", int'(test_en), 3);
        chk("R1 drivers still off in window", int'({drv_en_cv, drv_en_y}), 0);
        close_window(2'b00, 2'b01);
        chk("R6 composite woke", int'(drv_en_cv), 1);
        chk("R7 luma stayed asleep", int'(drv_en_y), 0);
        chk("R6 flags", int'(present), 1);
        chk("R10 tv_det", int'(tv_det), 1);
        chk("R5 test off after window", int'(test_en), 0);
        cmp_load = 2'b00;
        tick();
        chk("R2 done single cycle", int'(check_done), 0);
    endtask

    task automatic t_mixed();
        open_window();
        chk("R5 only asleep luma tested", int'(test_en), 2);
        close_window(2'b00, 2'b10);
        chk("R4 composite kept awake", int'(drv_en_cv), 1);
        chk("R7 luma on", int'(drv_en_y), 1);
        chk("R7 chroma follows luma", int'(drv_en_c), 1);
        chk("R6 flags both", int'(present), 3);
        cmp_load = 2'b00;
    endtask

    task automatic t_remove();
        open_window();
        chk("R5 no test on awake ports", int'(test_en), 0);
        close_window(2'b01, 2'b00);
        chk("R4 composite off", int'(drv_en_cv), 0);
        chk("R4 flags", int'(present), 2);
        chk("R7 luma unchanged", int'(drv_en_y), 1);
        cmp_level = 2'b00;
    endtask

    task automatic t_ce_low();
        chip_en = 1'b0;
        #1;
        chk("R11 drivers forced off", int'({drv_en_cv, drv_en_y, drv_en_c}), 0);
        fields(5);
        chk("R11 flags held", int'(present), 2);
        chk("R11 tv_det held", int'(tv_det), 1);
        chk("R11 no test current", int'(test_en), 0);
        chip_en = 1'b1;
        #1;
        chk("R11 luma resumes", int'(drv_en_y), 1);
        tick();
    endtask

    task automatic t_counter_reset();
        fields(40);
        chip_en = 1'b0;
        tick();
        chip_en = 1'b1;
        fields(63);
        chk("R8 counter cleared by chip_en", int'(test_en), 0);
        vsync_stb = 1'b1;
        tick();
        vsync_stb = 1'b0;
        chk("R1 window after 64 fresh strobes", int'(test_en), 1);
        close_window(2'b00, 2'b00);
        chk("R6 no load keeps asleep", int'(present), 2);
    endtask

    task automatic t_late_sample();
        open_window();
        cmp_load = 2'b01;
        close_window(2'b00, 2'b00);
        chk("R3 early comparator ignored", int'(present), 2);
        open_window();
        close_window(2'b00, 2'b01);
        chk("R3 last-cycle comparator used", int'(present), 3);
        cmp_load = 2'b00;
    endtask

    task automatic t_abort();
        open_window();
        tick(SETTLE - 1);
        cmp_level = 2'b11;
        chip_en = 1'b0;
        tick();
        chk("R8 no done on abort", int'(check_done), 0);
        chk("R8 flags unchanged on abort", int'(present), 3);
        chip_en = 1'b1;
        cmp_level = 2'b00;
        #1;
        chk("R8 drivers resume", int'({drv_en_cv, drv_en_y}), 3);
        tick(SETTLE + 2);
        chk("R8 no late done", int'(check_done), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_first_window();
        t_mixed();
        t_remove();
        t_ce_low();
        t_counter_reset();
        t_late_sample();
        t_abort();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule